// File: doc/BRIEF.md
# Parallel flash command sequencer

This block sits between a host and a byte-wide parallel flash that guards erase and program behind an unlock protocol. The host presents one request with an operation code, a target address and a data byte. The block then plays out the unlock and command write cycles on the flash pins and times each write cycle from parameters. It waits a fixed completion interval for the chosen operation and then pulses done. Flash reads and status polling are outside its job, so the host sees only the busy flag and the done pulse.

Two optional behaviours help a host that reaches the flash through a narrow address window. In auto mode the host sends only data writes. The first one after reset, or after a re-arm strobe, first erases the sector that holds its target, and every later one is a plain byte program. In remap mode, addresses inside a 4 KB window are rewired the way a board would wire them. Flash address bits 12 and 14 follow CPU bit 10 and flash bit 13 follows CPU bit 11, so the block issues its own command writes at CPU offsets 0x1555 and 0x1AAA.

All completion waits are computed from a clock-frequency parameter, so they hold at any system clock.

Top module: `flash_seq`

## Requirements
- R1: With reqOp 0 (or 3, which also means program), the flash sees exactly four writes: 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, then the data byte at the target. Done follows no earlier than 20 µs (CLK_HZ·20/10^6 cycles, rounded up) after the last write ends.
- R2: With reqOp 1, the flash sees exactly six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at the target. Done follows no earlier than 25 ms (CLK_HZ·25/1000 cycles).
- R3: With reqOp 2, the flash sees the same first five writes as R2 and then 0x10@0x5555. Done follows no earlier than 100 ms (CLK_HZ·100/1000 cycles).
- R4: While autoMode is 1, reqOp is ignored. The first request after reset or after an armAuto pulse performs the R2 sequence on its target, waits the erase time, and then performs the R1 sequence. Later requests perform R1 only.
- R5: While remapMode is 1 and CPU address bits 15:12 equal 0x1, the flash address is {a[10], a[11], a[10], a[11:0]}, so quarters 0x1000, 0x1400, 0x1800 and 0x1C00 land at 0x0000, 0x5400, 0x2800 and 0x7C00. Outside the window, and with the mode off, the flash address is a[14:0]. Command writes still reach 0x5555 and 0x2AAA.
- R6: In each write cycle, address and data are stable with CE low for at least SETUP_CYC cycles before WE falls. WE stays low for exactly PULSE_CYC cycles. Address and data stay stable with CE low for at least HOLD_CYC cycles after WE rises. CE is high between cycles.
- R7: reqReady equals not busy. A request is taken only while reqReady is 1, and one offered while busy has no effect on the flash. Done is a one-cycle pulse at the end of the final wait, and busy is 0 from that cycle on.
- R8: The flash data bus is driven only while CE is low and is high-impedance otherwise. OE stays high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a request |
| reqReady | output | 1 | Block can take a request |
| reqOp | input | 2 | 0/3 program, 1 sector erase, 2 chip erase |
| reqAddr | input | 16 | CPU-side target address |
| reqData | input | 8 | Byte to program |
| autoMode | input | 1 | Erase-on-first-write mode |
| remapMode | input | 1 | Apply window address remap |
| armAuto | input | 1 | Re-arm the auto-mode first-write erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| flashAddr | output | 15 | Flash address |
| flashDq | inout | 8 | Flash data bus |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| flashOeN | output | 1 | Flash output enable, held high |

## Verification
The bench logs every write cycle on the flash pins and compares its address and data against the exact order that each operation requires. A mixed-up command byte, a missing unlock write, or a sector erase that ends with the chip-erase write would all show up as a mismatch. The gap from the last write to done is held inside a narrow window for each operation, so a sequencer that used the wrong delay count is caught. The bench covers each of the four window quarters under remap, an address just outside the window, and op code 3. It also offers a request while busy and expects no extra writes, and drives auto mode through arm, a second write and a re-arm, where a design that erased on every write, or never, would produce the wrong number of cycles.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    KIND_PROG   = 2'd0,
    KIND_SERASE = 2'd1,
    KIND_CERASE = 2'd2
  } seqKind_t;

  // CMD_A reaches flash 0x5555, CMD_B reaches flash 0x2AAA
  typedef enum logic [1:0] {
    ASEL_CMD_A = 2'd0,
    ASEL_CMD_B = 2'd1,
    ASEL_TGT   = 2'd2
  } addrSel_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_GAP   = 3'd4
  } busPhase_t;

  typedef struct packed {
    logic     load;
    logic     start;
    addrSel_t addrSel;
    logic     useData;
    logic [7:0] cmdByte;
    logic     timerStart;
    seqKind_t waitKind;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       autoMode,
  input  logic       armAuto,
  input  logic       cycleDone,
  input  logic       timerDone,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_BUS, S_WAIT} ctlState_t;

  ctlState_t state;
  seqKind_t  kind;
  logic [2:0] idx;
  logic      pendProg;
  logic      armed;
  logic      accept;
  logic      lastStep;
  addrSel_t  stepSel;
  logic [7:0] stepByte;
  logic      stepUse;

  assign busy     = (state != S_IDLE);
  assign accept   = (state == S_IDLE) && reqValid;
  assign lastStep = (kind == KIND_PROG) ? (idx == 3'd3) : (idx == 3'd5);

  // unlock / command step table
  always_comb begin
    stepSel  = ASEL_CMD_A;
    stepByte = 8'hAA;
    stepUse  = 1'b0;
    if (kind == KIND_PROG) begin
      case (idx)
        3'd0:    begin stepSel = ASEL_CMD_A; stepByte = 8'hAA; end
        3'd1:    begin stepSel = ASEL_CMD_B; stepByte = 8'h55; end
        3'd2:    begin stepSel = ASEL_CMD_A; stepByte = 8'hA0; end
        default: begin stepSel = ASEL_TGT;   stepByte = 8'h00; stepUse = 1'b1; end
      endcase
    end else begin
      case (idx)
        3'd0:    begin stepSel = ASEL_CMD_A; stepByte = 8'hAA; end
        3'd1:    begin stepSel = ASEL_CMD_B; stepByte = 8'h55; end
        3'd2:    begin stepSel = ASEL_CMD_A; stepByte = 8'h80; end
        3'd3:    begin stepSel = ASEL_CMD_A; stepByte = 8'hAA; end
        3'd4:    begin stepSel = ASEL_CMD_B; stepByte = 8'h55; end
        default: begin
          if (kind == KIND_SERASE) begin stepSel = ASEL_TGT;   stepByte = 8'h30; end
          else                     begin stepSel = ASEL_CMD_A; stepByte = 8'h10; end
        end
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.load       = accept;
    ctl.start      = (state == S_SEND);
    ctl.addrSel    = stepSel;
    ctl.useData    = stepUse;
    ctl.cmdByte    = stepByte;
    ctl.timerStart = (state == S_BUS) && cycleDone && lastStep;
    ctl.waitKind   = kind;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      kind     <= KIND_PROG;
      idx      <= '0;
      pendProg <= 1'b0;
      armed    <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          idx      <= '0;
          state    <= S_SEND;
          pendProg <= 1'b0;
          if (autoMode) begin
            if (armed) begin
              kind     <= KIND_SERASE;
              pendProg <= 1'b1;
              armed    <= 1'b0;
            end else begin
              kind <= KIND_PROG;
            end
          end else begin
            case (reqOp)
              2'd1:    kind <= KIND_SERASE;
              2'd2:    kind <= KIND_CERASE;
              default: kind <= KIND_PROG;
            endcase
          end
        end
        S_SEND: state <= S_BUS;
        S_BUS: if (cycleDone) begin
          if (lastStep) state <= S_WAIT;
          else begin
            idx   <= idx + 3'd1;
            state <= S_SEND;
          end
        end
        S_WAIT: if (timerDone) begin
          if (pendProg) begin
            pendProg <= 1'b0;
            kind     <= KIND_PROG;
            idx      <= '0;
            state    <= S_SEND;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (armAuto) armed <= 1'b1;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned CPU_AW    = 16,
  parameter int unsigned FLASH_AW  = 15,
  parameter int unsigned DW        = 8
)(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [CPU_AW-1:0]   reqAddr,
  input  logic [DW-1:0]       reqData,
  input  logic                remapMode,
  output logic                cycleDone,
  output logic                timerDone,
  output logic [FLASH_AW-1:0] flashAddr,
  output logic [DW-1:0]       flashDqOut,
  output logic                flashDqOe,
  output logic                flashCeN,
  output logic                flashWeN
);

  localparam longint unsigned PROG_TICKS = (longint'(CLK_HZ) * 20 + 999_999) / 1_000_000;
  localparam longint unsigned SE_TICKS   = (longint'(CLK_HZ) * 25 + 999) / 1000;
  localparam longint unsigned CE_TICKS   = (longint'(CLK_HZ) * 100 + 999) / 1000;
  localparam int TW = $clog2(CE_TICKS + 1);
  localparam int PW = $clog2(SETUP_CYC + PULSE_CYC + HOLD_CYC + 1);
  localparam logic [CPU_AW-1:0] CMD_A_DIRECT = CPU_AW'(16'h5555);
  localparam logic [CPU_AW-1:0] CMD_B_DIRECT = CPU_AW'(16'h2AAA);
  localparam logic [CPU_AW-1:0] CMD_A_WIN    = CPU_AW'(16'h1555);
  localparam logic [CPU_AW-1:0] CMD_B_WIN    = CPU_AW'(16'h1AAA);

  logic [CPU_AW-1:0] tgtReg;
  logic [DW-1:0]     dataReg;
  logic              remapReg;
  busPhase_t         phase;
  logic [PW-1:0]     phCnt;
  logic [DW-1:0]     dqReg;
  logic [FLASH_AW-1:0] addrReg;
  logic [CPU_AW-1:0] cpuSel;
  logic [TW-1:0]     tCnt;
  logic              tRun;
  logic [TW-1:0]     tLoad;

  function automatic logic [FLASH_AW-1:0] mapAddr(input logic [CPU_AW-1:0] a, input logic en);
    if (en && a[15:12] == 4'h1) mapAddr = {a[10], a[11], a[10], a[11:0]};
    else                        mapAddr = a[FLASH_AW-1:0];
  endfunction

  always_comb begin
    case (ctl.addrSel)
      ASEL_CMD_A: cpuSel = remapReg ? CMD_A_WIN : CMD_A_DIRECT;
      ASEL_CMD_B: cpuSel = remapReg ? CMD_B_WIN : CMD_B_DIRECT;
      default:    cpuSel = tgtReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtReg   <= '0;
      dataReg  <= '0;
      remapReg <= 1'b0;
    end else if (ctl.load) begin
      tgtReg   <= reqAddr;
      dataReg  <= reqData;
      remapReg <= remapMode;
    end
  end

  // write-cycle timing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      phCnt   <= '0;
      dqReg   <= '0;
      addrReg <= '0;
    end else if (ctl.start) begin
      phase   <= PH_SETUP;
      phCnt   <= PW'(SETUP_CYC - 1);
      addrReg <= mapAddr(cpuSel, remapReg);
      dqReg   <= ctl.useData ? dataReg : ctl.cmdByte;
    end else begin
      case (phase)
        PH_SETUP: if (phCnt == '0) begin phase <= PH_PULSE; phCnt <= PW'(PULSE_CYC - 1); end
                  else phCnt <= phCnt - 1'b1;
        PH_PULSE: if (phCnt == '0) begin phase <= PH_HOLD; phCnt <= PW'(HOLD_CYC - 1); end
                  else phCnt <= phCnt - 1'b1;
        PH_HOLD:  if (phCnt == '0) phase <= PH_GAP;
                  else phCnt <= phCnt - 1'b1;
        PH_GAP:   phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  assign flashCeN   = !(phase == PH_SETUP || phase == PH_PULSE || phase == PH_HOLD);
  assign flashWeN   = (phase != PH_PULSE);
  assign flashDqOe  = !flashCeN;
  assign flashDqOut = dqReg;
  assign flashAddr  = addrReg;
  assign cycleDone  = (phase == PH_GAP);

  // completion timer
  always_comb begin
    case (ctl.waitKind)
      KIND_SERASE: tLoad = TW'(SE_TICKS - 1);
      KIND_CERASE: tLoad = TW'(CE_TICKS - 1);
      default:     tLoad = TW'(PROG_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tRun <= 1'b0;
      tCnt <= '0;
    end else if (ctl.timerStart) begin
      tRun <= 1'b1;
      tCnt <= tLoad;
    end else if (tRun) begin
      if (tCnt == '0) tRun <= 1'b0;
      else            tCnt <= tCnt - 1'b1;
    end
  end

  assign timerDone = tRun && (tCnt == '0);

  assert_setup_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWeN) |-> ($stable(flashAddr) && $stable(flashDqOut) && !flashCeN));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> ($stable(flashAddr) && $stable(flashDqOut) && !flashCeN));
  assert_ce_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCeN) |=> flashCeN);
  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |-> (phase == PH_IDLE && !tRun));
  assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> (phase == PH_IDLE && !tRun));

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned HOLD_CYC  = 1
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic [15:0] reqAddr,
  input  logic [7:0]  reqData,
  input  logic        autoMode,
  input  logic        remapMode,
  input  logic        armAuto,
  output logic        busy,
  output logic        done,
  output logic [14:0] flashAddr,
  inout  wire  [7:0]  flashDq,
  output logic        flashCeN,
  output logic        flashWeN,
  output logic        flashOeN
);

  ctlStrobe_t ctl;
  logic       cycleDone;
  logic       timerDone;
  logic [7:0] dqOut;
  logic       dqOe;

  flash_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .autoMode(autoMode), .armAuto(armAuto), .cycleDone(cycleDone),
    .timerDone(timerDone), .ctl(ctl), .busy(busy), .done(done)
  );

  flash_seq_dp #(
    .CLK_HZ(CLK_HZ), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC(HOLD_CYC), .CPU_AW(16), .FLASH_AW(15), .DW(8)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqData(reqData),
    .remapMode(remapMode), .cycleDone(cycleDone), .timerDone(timerDone),
    .flashAddr(flashAddr), .flashDqOut(dqOut), .flashDqOe(dqOe),
    .flashCeN(flashCeN), .flashWeN(flashWeN)
  );

  assign reqReady = !busy;
  assign flashDq  = dqOe ? dqOut : 8'bz;
  assign flashOeN = 1'b1;

endmodule

// File: tb/sim_flash_seq.sv
`timescale 1ns/1ps
module sim_flash_seq;

  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 1;
  // CLK_HZ = 500 kHz: 20 us -> 10, 25 ms -> 12500, 100 ms -> 50000 cycles
  localparam int W_PROG = 10;
  localparam int W_SE   = 12500;
  localparam int W_CE   = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqData = '0;
  logic autoMode = 1'b0;
  logic remapMode = 1'b0;
  logic armAuto = 1'b0;
  wire reqReady, busy, done, flashCeN, flashWeN, flashOeN;
  wire [14:0] flashAddr;
  wire [7:0] flashDq;

  always #2 clk = ~clk;

  flash_seq #(.CLK_HZ(500_000), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .autoMode(autoMode), .remapMode(remapMode),
    .armAuto(armAuto), .busy(busy), .done(done), .flashAddr(flashAddr), .flashDq(flashDq),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural flash write recorder
  logic [14:0] logA [128];
  logic [7:0]  logD [128];
  time riseT [128];
  time fallT [128];
  int logN = 0;
  int timingErr = 0;
  int busErr = 0;
  int stableRun = 0;
  int lowRun = 0;
  logic prevCe = 1'b1, prevWe = 1'b1;
  logic [14:0] prevA = '0;
  logic [7:0] prevD = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (flashOeN !== 1'b1) busErr++;
      if (flashCeN === 1'b1) begin
        if (flashDq !== 8'hzz) busErr++;
        if (flashWeN !== 1'b1) busErr++;
      end else if (^flashDq === 1'bx) busErr++;
      if (flashCeN === 1'b0 && prevCe === 1'b0 && (flashAddr !== prevA || flashDq !== prevD))
        timingErr++;
      if (flashCeN === 1'b0 && flashWeN === 1'b1)
        stableRun = (prevCe === 1'b0 && prevWe === 1'b1) ? stableRun + 1 : 1;
      if (flashWeN === 1'b0) lowRun = (prevWe === 1'b0) ? lowRun + 1 : 1;
      if (prevWe === 1'b1 && flashWeN === 1'b0) begin
        if (stableRun < SETUP) timingErr++;
        fallT[logN & 127] = $time;
      end
      if (prevWe === 1'b0 && flashWeN === 1'b1) begin
        if (lowRun != PULSE) timingErr++;
        logA[logN & 127] = prevA;
        logD[logN & 127] = prevD;
        riseT[logN & 127] = $time;
        logN++;
      end
      if (prevCe === 1'b0 && flashCeN === 1'b1 && stableRun < HOLD) timingErr++;
    end
    prevCe = flashCeN;
    prevWe = flashWeN;
    prevA  = flashAddr;
    prevD  = flashDq;
  end

  // expected write list built from the requirements
  logic [14:0] expA [16];
  logic [7:0]  expD [16];
  int expN;

  task automatic addW(input logic [14:0] a, input logic [7:0] d);
    expA[expN] = a; expD[expN] = d; expN++;
  endtask

  task automatic addSeq(input int kind, input logic [14:0] tgt, input logic [7:0] d);
    addW(15'h5555, 8'hAA); addW(15'h2AAA, 8'h55);
    if (kind == 0) begin
      addW(15'h5555, 8'hA0); addW(tgt, d);
    end else begin
      addW(15'h5555, 8'h80); addW(15'h5555, 8'hAA); addW(15'h2AAA, 8'h55);
      if (kind == 1) addW(tgt, 8'h30); else addW(15'h5555, 8'h10);
    end
  endtask

  task automatic compareLog(input int base, input string req, input string tag);
    check(logN - base == expN, req, {tag, " write count"}, logN - base, expN);
    for (int i = 0; i < expN && i < logN - base; i++) begin
      check(logA[(base + i) & 127] == expA[i], req, $sformatf("%s addr of write %0d", tag, i),
            logA[(base + i) & 127], expA[i]);
      check(logD[(base + i) & 127] == expD[i], req, $sformatf("%s data of write %0d", tag, i),
            logD[(base + i) & 127], expD[i]);
    end
  endtask

  task automatic sendReq(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                         input logic rm);
    reqOp = op; reqAddr = a; reqData = d; remapMode = rm; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(input string req, output time dT);
    int n = 0;
    while (done !== 1'b1 && n < 70000) begin @(negedge clk); n++; end
    dT = $time;
    check(done === 1'b1, req, "done seen", done, 1);
    check(busy === 1'b0, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
  endtask

  task automatic checkWait(input string req, input time fromT, input time toT, input int w);
    longint c = longint'((toT - fromT) / 4);
    check(c >= w && c <= w + HOLD + 4, req, "completion wait cycles", c, w);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        remap;
    logic [14:0] tgt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 16'h0123, 8'h5A, 1'b0, 15'h0123},  // R1 plain program
    '{2'd0, 16'h1437, 8'hC3, 1'b1, 15'h5437},  // R5 second quarter
    '{2'd0, 16'h1C05, 8'h0F, 1'b1, 15'h7C05},  // R5 fourth quarter
    '{2'd0, 16'h1801, 8'hF0, 1'b1, 15'h2801},  // R5 third quarter
    '{2'd1, 16'h1234, 8'h00, 1'b0, 15'h1234},  // R2 sector erase
    '{2'd0, 16'h2345, 8'h99, 1'b1, 15'h2345},  // R5 outside window
    '{2'd3, 16'h7FFF, 8'h01, 1'b0, 15'h7FFF},  // R1 op code 3
    '{2'd2, 16'h1077, 8'h00, 1'b1, 15'h0077}   // R3 chip erase, R5 first quarter
  };

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    time dT;
    string rq;
    repeat (4) @(negedge clk);
    // reset state
    check(busy === 1'b0 && reqReady === 1'b1, "R7", "reset handshake", {busy, reqReady}, 1);
    check(flashCeN === 1'b1 && flashWeN === 1'b1, "R6", "reset strobes", {flashCeN, flashWeN}, 3);
    check(flashOeN === 1'b1 && flashDq === 8'hzz, "R8", "reset bus released", flashOeN, 1);
    check(done === 1'b0, "R7", "reset done", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[k]) begin
      base = logN;
      expN = 0;
      addSeq((VECS[k].op == 2'd3) ? 0 : int'(VECS[k].op), VECS[k].tgt, VECS[k].data);
      rq = (VECS[k].op == 2'd1) ? "R2" : (VECS[k].op == 2'd2) ? "R3" : "R1";
      sendReq(VECS[k].op, VECS[k].addr, VECS[k].data, VECS[k].remap);
      check(busy === 1'b1 && reqReady === 1'b0, "R7", "busy after accept", busy, 1);
      waitDone(rq, dT);
      compareLog(base, VECS[k].remap ? "R5" : rq, $sformatf("vec%0d", k));
      checkWait(rq, riseT[(logN - 1) & 127], dT,
                (VECS[k].op == 2'd1) ? W_SE : (VECS[k].op == 2'd2) ? W_CE : W_PROG);
      repeat (3) @(negedge clk);
    end

    // R7: request offered while busy has no effect
    base = logN; expN = 0;
    addSeq(1, 15'h0400, 8'h00);
    sendReq(2'd1, 16'h0400, 8'h00, 1'b0);
    repeat (100) @(negedge clk);
    check(reqReady === 1'b0, "R7", "ready low while busy", reqReady, 0);
    sendReq(2'd2, 16'h0000, 8'hEE, 1'b0);
    waitDone("R7", dT);
    repeat (40) @(negedge clk);
    compareLog(base, "R7", "busy reject");
    check(busy === 1'b0, "R7", "idle after rejected request", busy, 0);

    // R4: auto mode, armed by reset, op ignored, remapped target
    autoMode = 1'b1;
    base = logN; expN = 0;
    addSeq(1, 15'h5555, 8'h00);
    addSeq(0, 15'h5555, 8'h3C);
    sendReq(2'd2, 16'h1555, 8'h3C, 1'b1);
    waitDone("R4", dT);
    compareLog(base, "R4", "auto first");
    if (logN - base == 10) begin
      checkWait("R4", riseT[(base + 5) & 127], fallT[(base + 6) & 127], W_SE);
      checkWait("R4", riseT[(base + 9) & 127], dT, W_PROG);
    end
    repeat (3) @(negedge clk);

    base = logN; expN = 0;
    addSeq(0, 15'h5402, 8'h11);
    sendReq(2'd1, 16'h1402, 8'h11, 1'b1);
    waitDone("R4", dT);
    compareLog(base, "R4", "auto later");
    repeat (3) @(negedge clk);

    armAuto = 1'b1;
    @(negedge clk);
    armAuto = 1'b0;
    base = logN; expN = 0;
    addSeq(1, 15'h0010, 8'h00);
    addSeq(0, 15'h0010, 8'h77);
    sendReq(2'd0, 16'h0010, 8'h77, 1'b0);
    waitDone("R4", dT);
    compareLog(base, "R4", "auto rearmed");
    autoMode = 1'b0;
    repeat (3) @(negedge clk);

    check(timingErr == 0, "R6", "write cycle timing violations", timingErr, 0);
    check(busErr == 0, "R8", "bus drive / OE violations", busErr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule